// File: doc/BRIEF.md
# Triggered Four-Channel ADC Scan Sequencer

This block sequences a successive-approximation converter core through a group of four adjacent analog channels, repeating the group for as long as it stays armed. Software enables the block, writes a start bit and selects a channel group. The first conversion does not begin until a hardware trigger pulse arrives. From then on the block steps through the four channels. It latches each finished conversion into a result register and pulses an end-of-conversion interrupt. After the last channel it wraps back to the first without needing another trigger.

The following events abort the conversion in flight and throw away its partial result: a new trigger, a rewrite of the start bit with 1, or a write to the group-select register. The scan then restarts at the first channel of the group that is current at that moment. Clearing the start bit also aborts the conversion, and the block then waits in standby, where triggers have no effect. Clearing the enable bit puts the block in its stop state. The abort reaches the core in the same cycle as its cause. A done pulse that arrives in that same cycle is discarded.

Top module: `adc_scan_seq`

## Requirements
- R1: While `en_i` is 0, the block is stopped. A start write of 1 is ignored, and triggers start no conversion: `core_start_o` stays 0.
- R2: Clearing `en_i` in any state returns the block to stop and clears the armed start bit. After enable is set again, a trigger alone starts nothing until start is written with 1.
- R3: Writing 1 to start while enabled arms the block without converting. The first `core_start_o` pulse comes in the cycle after a trigger, with `core_chan_o` at the group's first channel.
- R4: Group-select value g selects channels 4g to 4g+3 (0 gives channels 0-3, 1 gives 4-7). The channels are converted in ascending order, beginning at slot 0.
- R5: A done pulse during an unaborted conversion stores `core_result_i` in `result_o`. It also gives a one-cycle `eoc_irq_o` pulse and a `core_start_o` for the next slot, both in the following cycle.
- R6: After slot 3 completes, the next conversion starts automatically at the group's first channel.
- R7: A trigger during a conversion raises `core_abort_o` in the same cycle. The next cycle restarts at the group's first channel.
- R8: A group-select write during a conversion raises `core_abort_o` in the same cycle. The next cycle restarts at the first channel of the newly written group.
- R9: Writing start with 1 during a conversion raises `core_abort_o` in the same cycle. The next cycle restarts at the group's first channel.
- R10: Writing start with 0 during a conversion raises `core_abort_o` and moves the block to standby. Later triggers start no conversion.
- R11: A done pulse in an aborted cycle is discarded: no interrupt, and `result_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable level |
| start_wr_i | input | 1 | Start-bit write strobe |
| start_val_i | input | 1 | Value written to the start bit |
| grp_wr_i | input | 1 | Group-select write strobe |
| grp_val_i | input | GSEL_W | Group-select value written |
| trig_i | input | 1 | Hardware trigger pulse |
| core_done_i | input | 1 | Conversion-complete pulse from core |
| core_result_i | input | RES_W | Conversion result from core |
| core_start_o | output | 1 | Start pulse to core |
| core_abort_o | output | 1 | Abort of current conversion |
| core_chan_o | output | GSEL_W+log2(SCAN_LEN) | Channel for the conversion being started |
| result_o | output | RES_W | Latched last result |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |

## Verification
The main scan is run with both group values. Each run pulses a re-trigger after a different number of completions: some before the wrap and some after it. This separates a wrong base channel from a wrong slot order, and separates a wrap that skips or repeats a slot from a restart that leaves the slot counter where it was. The bench's core model places the channel number in the upper result bits, so a mismatch between channel and stored result shows up directly. Directed tests with a hand-driven core make a done pulse coincide with each abort cause. This tells a correctly suppressed completion apart from one that leaks into the result register or the interrupt.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ARMED = 2'd2,
    ST_CONV  = 2'd3
  } scan_state_e;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_wr_i,
  input  logic start_val_i,
  input  logic grp_wr_i,
  input  logic trig_i,
  input  logic done_i,
  output logic load_first_o,
  output logic advance_o,
  output logic abort_o,
  output logic kick_o
);
  scan_state_e st_q, st_n;
  logic in_conv, wr_one, wr_zero;

  assign in_conv = (st_q == ST_CONV);
  assign wr_one  = start_wr_i & start_val_i;
  assign wr_zero = start_wr_i & ~start_val_i;

  // any cause in a converting cycle discards the conversion right away
  assign abort_o = in_conv & (~en_i | trig_i | grp_wr_i | start_wr_i);
  assign advance_o = in_conv & done_i & ~abort_o;
  assign load_first_o = en_i & ~wr_zero &
                        (((st_q == ST_ARMED) & trig_i) |
                         (in_conv & (trig_i | grp_wr_i | wr_one)));

  always_comb begin
    st_n = st_q;
    if (!en_i) begin
      st_n = ST_STOP;
    end else begin
      unique case (st_q)
        ST_STOP, ST_IDLE: st_n = wr_one ? ST_ARMED : ST_IDLE;
        ST_ARMED:         st_n = wr_zero ? ST_IDLE : (trig_i ? ST_CONV : ST_ARMED);
        ST_CONV:          st_n = wr_zero ? ST_IDLE : ST_CONV;
        default:          st_n = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_STOP;
      kick_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      kick_o <= load_first_o | advance_o;
    end
  end

  assert_off_no_kick_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !kick_o);
  assert_disable_stops_R2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> st_q == ST_STOP);
  assert_armed_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ARMED && !trig_i) |=> !kick_o);
  assert_clear_idles_R10: assert property (@(posedge clk) disable iff (rst)
    (in_conv && wr_zero && en_i) |=> (st_q == ST_IDLE && !kick_o));
endmodule

// File: rtl/adc_scan_slots.sv
module adc_scan_slots #(
  parameter int GSEL_W   = 1,
  parameter int SCAN_LEN = 4,
  parameter int SLOT_W   = $clog2(SCAN_LEN),
  parameter int CH_W     = GSEL_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_wr_i,
  input  logic [GSEL_W-1:0] grp_val_i,
  input  logic              load_first_i,
  input  logic              advance_i,
  output logic [CH_W-1:0]   chan_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SCAN_LEN - 1);

  logic [GSEL_W-1:0] grp_q, grp_eff, base_q;
  logic [SLOT_W-1:0] slot_q, slot_nx;

  assign grp_eff = grp_wr_i ? grp_val_i : grp_q;
  assign slot_nx = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q  <= '0;
      base_q <= '0;
      slot_q <= '0;
      chan_o <= '0;
    end else begin
      if (grp_wr_i) grp_q <= grp_val_i;
      if (load_first_i) begin
        base_q <= grp_eff;
        slot_q <= '0;
        chan_o <= {grp_eff, {SLOT_W{1'b0}}};
      end else if (advance_i) begin
        slot_q <= slot_nx;
        chan_o <= {base_q, slot_nx};
      end
    end
  end

  assert_new_group_base_R8: assert property (@(posedge clk) disable iff (rst)
    (load_first_i && grp_wr_i) |=> chan_o == {$past(grp_val_i), {SLOT_W{1'b0}}});
  assert_wrap_first_R6: assert property (@(posedge clk) disable iff (rst)
    (advance_i && !load_first_i && slot_q == LAST_SLOT) |=> chan_o[SLOT_W-1:0] == '0);
endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             abort_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= accept_i;
      if (accept_i) result_o <= data_i;
    end
  end

  assert_abort_no_irq_R11: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!irq_o && $stable(result_o)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int GSEL_W   = 1,
  parameter int SCAN_LEN = 4,
  parameter int RES_W    = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 en_i,
  input  logic                                 start_wr_i,
  input  logic                                 start_val_i,
  input  logic                                 grp_wr_i,
  input  logic [GSEL_W-1:0]                    grp_val_i,
  input  logic                                 trig_i,
  input  logic                                 core_done_i,
  input  logic [RES_W-1:0]                     core_result_i,
  output logic                                 core_start_o,
  output logic                                 core_abort_o,
  output logic [GSEL_W+$clog2(SCAN_LEN)-1:0]   core_chan_o,
  output logic [RES_W-1:0]                     result_o,
  output logic                                 eoc_irq_o
);
  localparam int SLOT_W = $clog2(SCAN_LEN);
  localparam int CH_W   = GSEL_W + SLOT_W;

  logic load_first, advance;

  adc_scan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en_i(en_i),
    .start_wr_i(start_wr_i), .start_val_i(start_val_i),
    .grp_wr_i(grp_wr_i), .trig_i(trig_i), .done_i(core_done_i),
    .load_first_o(load_first), .advance_o(advance),
    .abort_o(core_abort_o), .kick_o(core_start_o)
  );

  adc_scan_slots #(.GSEL_W(GSEL_W), .SCAN_LEN(SCAN_LEN), .SLOT_W(SLOT_W), .CH_W(CH_W)) u_slots (
    .clk(clk), .rst(rst), .grp_wr_i(grp_wr_i), .grp_val_i(grp_val_i),
    .load_first_i(load_first), .advance_i(advance), .chan_o(core_chan_o)
  );

  adc_scan_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .accept_i(advance), .abort_i(core_abort_o),
    .data_i(core_result_i), .result_o(result_o), .irq_o(eoc_irq_o)
  );

  assert_irq_needs_done_R5: assert property (@(posedge clk) disable iff (rst)
    eoc_irq_o |-> $past(core_done_i && !core_abort_o));
  assert_restart_on_trig_R7: assert property (@(posedge clk) disable iff (rst)
    (core_abort_o && trig_i && en_i && !start_wr_i && !grp_wr_i) |=>
      (core_start_o && core_chan_o[SLOT_W-1:0] == '0));
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int LAT = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, swr = 0, sval = 0, gwr = 0, gval = 0, trig = 0;
  logic man = 1'b1, man_done = 0;
  logic [9:0] man_res = '0;
  logic core_start, core_abort, irq, done;
  logic [2:0] chan;
  logic [9:0] result, core_res;

  logic m_busy = 0, m_done = 0;
  logic [3:0] m_cnt = '0;
  logic [6:0] m_tag = '0;
  logic [2:0] m_chan = '0;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  assign done     = man ? man_done : m_done;
  assign core_res = man ? man_res : {m_chan, m_tag};

  adc_scan_seq dut_i (
    .clk(clk), .rst(rst), .en_i(en), .start_wr_i(swr), .start_val_i(sval),
    .grp_wr_i(gwr), .grp_val_i(gval), .trig_i(trig),
    .core_done_i(done), .core_result_i(core_res),
    .core_start_o(core_start), .core_abort_o(core_abort), .core_chan_o(chan),
    .result_o(result), .eoc_irq_o(irq)
  );

  // behavioural core: done LAT cycles after a start, result carries the channel
  always @(posedge clk) begin
    m_done <= 1'b0;
    if (core_start) begin
      m_busy <= 1'b1; m_cnt <= 4'(LAT); m_tag <= m_tag + 1'b1; m_chan <= chan;
    end else if (core_abort) begin
      m_busy <= 1'b0;
    end else if (m_busy) begin
      if (m_cnt == 4'd1) begin m_done <= 1'b1; m_busy <= 1'b0; end
      m_cnt <= m_cnt - 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_start(input logic v);
    swr = 1; sval = v; tick(); swr = 0;
  endtask

  task automatic pulse_trig(); trig = 1; tick(); trig = 0; endtask

  task automatic wait_irq(input int exp_ch, input string req);
    int n = 0;
    while (!irq && n < 200) begin tick(); n++; end
    chk(irq == 1'b1, req, int'(irq), 1);
    chk(int'(result[9:7]) == exp_ch, req, int'(result[9:7]), exp_ch);
    tick();
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (core_start) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  // {group, completions before re-trigger}
  localparam logic [3:0] VEC [3] = '{ {1'b0, 3'd2}, {1'b1, 3'd3}, {1'b0, 3'd5} };

  initial begin : watchdog
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [9:0] held;
    int base;
    repeat (3) tick();
    rst = 0; tick();
    chk(!core_start && !core_abort && !irq && result == '0, "reset", int'(result), 0);

    // table walk with the auto core: R4 R5 R6 R7
    man = 0; en = 1; tick();
    foreach (VEC[v]) begin
      base = 4 * int'(VEC[v][3]);
      wr_start(1'b0);
      gwr = 1; gval = VEC[v][3]; tick(); gwr = 0;
      wr_start(1'b1);
      pulse_trig();
      for (int i = 0; i < int'(VEC[v][2:0]); i++) wait_irq(base + (i % 4), "R4_R5");
      pulse_trig();
      for (int i = 0; i < 5; i++) wait_irq(base + (i % 4), "R6_R7");
    end

    // directed, hand-driven core
    man = 1; en = 0; wr_start(1'b0);
    rst = 1; tick(); rst = 0; tick();
    wr_start(1'b1); pulse_trig();
    quiet(10, "R1");
    en = 1; tick();
    quiet(6, "R2");
    wr_start(1'b1);
    quiet(8, "R3");
    trig = 1; tick(); trig = 0;
    chk(core_start && chan == 3'd0, "R3", int'(chan), 0);
    repeat (3) tick();
    held = result;
    trig = 1; man_done = 1; man_res = 10'h3ff; #1;
    chk(core_abort == 1'b1, "R7", int'(core_abort), 1);
    tick(); trig = 0; man_done = 0;
    chk(!irq && result == held, "R11", int'(result), int'(held));
    chk(core_start && chan == 3'd0, "R7", int'(chan), 0);
    repeat (2) tick();
    man_done = 1; man_res = 10'h155; tick(); man_done = 0;
    chk(irq && result == 10'h155, "R5", int'(result), 'h155);
    chk(core_start && chan == 3'd1, "R4", int'(chan), 1);
    tick();
    chk(!irq, "R5", int'(irq), 0);
    for (int s = 2; s < 5; s++) begin
      man_done = 1; tick(); man_done = 0;
      chk(core_start && chan == 3'(s % 4), "R6", int'(chan), s % 4);
    end
    tick();
    gwr = 1; gval = 1; man_done = 1; #1;
    chk(core_abort == 1'b1, "R8", int'(core_abort), 1);
    tick(); gwr = 0; man_done = 0;
    chk(core_start && chan == 3'd4 && !irq, "R8", int'(chan), 4);
    tick(); tick();
    swr = 1; sval = 1; #1;
    chk(core_abort == 1'b1, "R9", int'(core_abort), 1);
    tick(); swr = 0;
    chk(core_start && chan == 3'd4, "R9", int'(chan), 4);
    tick();
    swr = 1; sval = 0; #1;
    chk(core_abort == 1'b1, "R10", int'(core_abort), 1);
    tick(); swr = 0;
    pulse_trig();
    quiet(10, "R10");
    wr_start(1'b1);
    en = 0; tick(); en = 1; tick();
    pulse_trig();
    quiet(10, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule